// File: doc/BRIEF.md
# Memory-Cycle Strobe Generator

This block produces the control strobes for one local memory bus. Three kinds of device share a multiplexed address bus on that bus: DRAM, a boot EPROM and a small address ROM. Every memory cycle lasts sixteen clock periods, called slots, and a 4-bit phase counter steps through them. A cycle begins when the block is idle and sees either an access request (read or write) or a refresh request. At that start the block captures the 21-bit word address, the read/write flag and the boot-mode bit. It holds them for the whole cycle.

The block decodes the captured address against two regions. The first is the address-ROM window at the bottom of memory. The second is the EPROM space, which counts only while the boot bit is 0. The decode controls three outputs: the column strobe, the DRAM output enable and the ROM select. The ROM select pin is time-shared. Early in the cycle it acts as a chip select, and later in the cycle it carries address bit 13. A refresh cycle asserts the column strobe before the row strobe (CAS-before-RAS). The block also combines two reset sources into a memory-bus reset output for external glue logic.

Top module: `mem_strobe_gen`

## Requirements
- R1: On read and write cycles, `ras_n_o` is low in slots 0 to 4 and high in slots 5 to 15.
- R2: On a read or write cycle to DRAM, `cas_n_o` is low in slots 5 to 7 and high in all other slots.
- R3: `cas_n_o` stays high for the whole cycle in two cases. The first is an access to the address-ROM window 0x000000–0x00000F. The second applies while the boot bit is 0: an access to 0x000010–0x00FFFF or to 0x1F0000–0x1FFFFF, which is EPROM space. While the boot bit is 1, those two ranges count as DRAM.
- R4: On a refresh cycle, `cas_n_o` is low in slots 0 to 4 and `ras_n_o` is low in slots 1 to 5. The column strobe therefore falls one slot before the row strobe.
- R5: `refresh_o` is high in all sixteen slots of a refresh cycle. It is low during access cycles and while idle.
- R6: In slots 0 to 4, `romsel_n_o` is low only for a read from EPROM space while the boot bit is 0. It is high in slots 0 to 4 for writes, for other addresses, and whenever the boot bit is 1.
- R7: In slots 5 to 15 of a read or write cycle, `romsel_n_o` equals bit 13 of the captured address. During refresh cycles and while idle it is high.
- R8: `oe_n_o` is low in slots 5 to 15 of a DRAM read cycle only. It is high for EPROM reads, address-ROM reads, writes and refresh cycles.
- R9: `dir_o` is 1 in every slot of a write cycle. It is 0 on reads, on refresh cycles and while idle.
- R10: `mrst_n_o` is low whenever `sys_reset_i` or `soft_reset_i` is 1, and high when both are 0.
- R11: The block accepts a request only while idle. The first slot follows the clock edge that accepts the request. When both requests arrive together, refresh wins. Requests made during a cycle are ignored. Between cycles, and after reset, every strobe is inactive: `ras_n_o`, `cas_n_o`, `oe_n_o` and `romsel_n_o` are high, and `dir_o` and `refresh_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| start_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 selects write, 0 selects read |
| refresh_i | input | 1 | Refresh request; beats `start_i` |
| boot_i | input | 1 | Boot mode; 0 means code runs from EPROM |
| addr_i | input | 21 | Word address of the access |
| sys_reset_i | input | 1 | System reset source, active high |
| soft_reset_i | input | 1 | Software reset control, active high |
| ras_n_o | output | 1 | Row-address strobe, active low |
| cas_n_o | output | 1 | Column-address strobe, active low |
| oe_n_o | output | 1 | DRAM output enable, active low |
| romsel_n_o | output | 1 | ROM chip select early, address bit 13 late |
| dir_o | output | 1 | Data direction, 1 = write |
| refresh_o | output | 1 | Refresh cycle in progress |
| mrst_n_o | output | 1 | Memory-bus reset, active low |

## Verification
The bench runs every combination of the three cycle kinds, both boot settings and twelve addresses. The addresses sit on each edge of every decode region, and some of them have bit 13 set and others have it clear. Every output is compared in every slot. Flipping only the boot bit on the same EPROM address separates DRAM from EPROM treatment. Flipping only the address across 0x00000F/0x000010 and 0x1EFFFF/0x1F0000 tests each range boundary, and bit-13 patterns expose the late ROM-select function. Separate runs cover simultaneous requests, a request raised partway through a cycle, and all four combinations of the reset sources.

// File: rtl/msg_pkg.sv
package msg_pkg;
    typedef enum logic [1:0] {
        CYC_READ    = 2'd0,
        CYC_WRITE   = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_kind_e;
endpackage

// File: rtl/msg_addr_decode.sv
module msg_addr_decode #(
    parameter int ADDR_W = 21,
    parameter logic [ADDR_W-1:0] ROM_TOP   = 21'h00000F,
    parameter logic [ADDR_W-1:0] LOW_TOP   = 21'h00FFFF,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 21'h1F0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              boot_i,
    output logic              rom_hit_o,
    output logic              eprom_hit_o
);
    logic low_win, high_win;

    always_comb begin
        rom_hit_o   = (addr_i <= ROM_TOP);
        low_win     = (addr_i > ROM_TOP) && (addr_i <= LOW_TOP);
        high_win    = (addr_i >= HIGH_BASE);
        eprom_hit_o = !boot_i && (low_win || high_win);
    end
endmodule

// File: rtl/msg_sequencer.sv
module msg_sequencer
    import msg_pkg::*;
#(
    parameter int PH_W   = 4,
    parameter int ADDR_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              we_i,
    input  logic              refresh_i,
    input  logic              boot_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              busy_o,
    output logic [PH_W-1:0]   phase_o,
    output cyc_kind_e         kind_o,
    output logic              boot_o,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [PH_W-1:0] LAST = '1;

    typedef struct packed {
        logic              busy;
        logic [PH_W-1:0]   phase;
        cyc_kind_e         kind;
        logic              boot;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (refresh_i || start_i) begin
                s_d.busy  = 1'b1;
                s_d.phase = '0;
                s_d.addr  = addr_i;
                s_d.boot  = boot_i;
                if (refresh_i)  s_d.kind = CYC_REFRESH;
                else if (we_i)  s_d.kind = CYC_WRITE;
                else            s_d.kind = CYC_READ;
            end
        end else begin
            if (s_q.phase == LAST) s_d.busy = 1'b0;
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = s_q.busy;
    assign phase_o = s_q.phase;
    assign kind_o  = s_q.kind;
    assign boot_o  = s_q.boot;
    assign addr_o  = s_q.addr;

    // R11: slots advance one per clock inside a cycle
    assert_phase_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.phase != LAST) |=> (s_q.busy && s_q.phase == PH_W'($past(s_q.phase) + 1'b1)));

    // R11: refresh wins over a simultaneous access request
    assert_refresh_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && refresh_i && start_i) |=> (s_q.kind == CYC_REFRESH));

    // R11: a request during a cycle does not restart the counter
    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.phase != LAST && start_i) |=> (s_q.phase != '0));
endmodule

// File: rtl/mem_strobe_gen.sv
module mem_strobe_gen
    import msg_pkg::*;
#(
    parameter int PH_W       = 4,
    parameter int ADDR_W     = 21,
    parameter int RAS_SLOTS  = 5,
    parameter int CAS_SLOTS  = 3,
    parameter int CSEL_SLOTS = 5,
    parameter int ROM_ABIT   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              we_i,
    input  logic              refresh_i,
    input  logic              boot_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sys_reset_i,
    input  logic              soft_reset_i,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              oe_n_o,
    output logic              romsel_n_o,
    output logic              dir_o,
    output logic              refresh_o,
    output logic              mrst_n_o
);
    localparam logic [PH_W-1:0] RAS_END  = PH_W'(RAS_SLOTS);
    localparam logic [PH_W-1:0] CAS_END  = PH_W'(RAS_SLOTS + CAS_SLOTS);
    localparam logic [PH_W-1:0] CSEL_END = PH_W'(CSEL_SLOTS);
    localparam logic [PH_W-1:0] LAST     = '1;

    logic              busy;
    logic [PH_W-1:0]   phase;
    cyc_kind_e         kind;
    logic              boot_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rom_hit, eprom_hit;

    msg_sequencer #(.PH_W(PH_W), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .we_i(we_i),
        .refresh_i(refresh_i), .boot_i(boot_i), .addr_i(addr_i),
        .busy_o(busy), .phase_o(phase), .kind_o(kind),
        .boot_o(boot_q), .addr_o(addr_q)
    );

    msg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i(addr_q), .boot_i(boot_q),
        .rom_hit_o(rom_hit), .eprom_hit_o(eprom_hit)
    );

    logic is_ref, is_rd, is_wr, dram, early;

    always_comb begin
        is_ref = busy && (kind == CYC_REFRESH);
        is_rd  = busy && (kind == CYC_READ);
        is_wr  = busy && (kind == CYC_WRITE);
        dram   = !rom_hit && !eprom_hit;
        early  = (phase < CSEL_END);

        ras_n_o    = 1'b1;
        cas_n_o    = 1'b1;
        oe_n_o     = 1'b1;
        romsel_n_o = 1'b1;
        if (is_ref) begin
            cas_n_o = !(phase < RAS_END);
            ras_n_o = !((phase != '0) && (phase <= RAS_END));
        end else if (is_rd || is_wr) begin
            ras_n_o    = !(phase < RAS_END);
            cas_n_o    = !(dram && (phase >= RAS_END) && (phase < CAS_END));
            oe_n_o     = !(is_rd && dram && (phase >= RAS_END));
            romsel_n_o = early ? !(is_rd && eprom_hit) : addr_q[ROM_ABIT];
        end
        dir_o     = is_wr;
        refresh_o = is_ref;
        mrst_n_o  = !(sys_reset_i || soft_reset_i);
    end

    // R2: row and column strobes never overlap on access cycles
    assert_no_rc_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind != CYC_REFRESH) |-> (ras_n_o || cas_n_o));

    // R4: on refresh the column strobe is already low when the row strobe falls
    assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_o && $fell(ras_n_o)) |-> !cas_n_o);

    // R5: refresh indicator holds through the cycle
    assert_refresh_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_o && phase != LAST) |=> refresh_o);

    // R6: early chip select only for reads in EPROM mode
    assert_romsel_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && early && !romsel_n_o) |-> (kind == CYC_READ && !boot_q));

    // R8: DRAM outputs never enabled while the bus direction says write
    assert_oe_not_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> !dir_o);
endmodule

// File: tb/sim_mem_strobe_gen.sv
module sim_mem_strobe_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, we_i = 1'b0, refresh_i = 1'b0, boot_i = 1'b0;
    logic [20:0] addr_i = '0;
    logic        sys_reset_i = 1'b0, soft_reset_i = 1'b0;
    logic        ras_n_o, cas_n_o, oe_n_o, romsel_n_o, dir_o, refresh_o, mrst_n_o;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    mem_strobe_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .we_i(we_i),
        .refresh_i(refresh_i), .boot_i(boot_i), .addr_i(addr_i),
        .sys_reset_i(sys_reset_i), .soft_reset_i(soft_reset_i),
        .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .oe_n_o(oe_n_o),
        .romsel_n_o(romsel_n_o), .dir_o(dir_o), .refresh_o(refresh_o),
        .mrst_n_o(mrst_n_o)
    );

    localparam logic [20:0] ADDRS [12] = '{
        21'h000000, 21'h00000F, 21'h000010, 21'h002000,
        21'h00FFFF, 21'h010000, 21'h012000, 21'h1EFFFF,
        21'h1F0000, 21'h1F2000, 21'h1FFFFF, 21'h0A5A5A
    };

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(req, "idle ras_n", ras_n_o, 1'b1);
        chk(req, "idle cas_n", cas_n_o, 1'b1);
        chk(req, "idle oe_n", oe_n_o, 1'b1);
        chk(req, "idle romsel_n", romsel_n_o, 1'b1);
        chk(req, "idle dir", dir_o, 1'b0);
        chk(req, "idle refresh", refresh_o, 1'b0);
    endtask

    // kind: 0 read, 1 write, 2 refresh
    task automatic chk_slot(input int kind, input logic [20:0] a, input logic b, input int s);
        logic ref_c, wr, rd, eprom, rom, dram;
        ref_c = (kind == 2);
        wr    = (kind == 1);
        rd    = (kind == 0);
        rom   = (a <= 21'h00000F);
        eprom = !b && ((a >= 21'h000010 && a <= 21'h00FFFF) || a >= 21'h1F0000);
        dram  = !rom && !eprom;
        if (ref_c) begin
            chk("R4", "ref ras_n", ras_n_o, !(s >= 1 && s <= 5));
            chk("R4", "ref cas_n", cas_n_o, !(s < 5));
            chk("R7", "ref romsel_n", romsel_n_o, 1'b1);
        end else begin
            chk("R1", "ras_n", ras_n_o, !(s < 5));
            chk(dram ? "R2" : "R3", "cas_n", cas_n_o, !(dram && s >= 5 && s < 8));
            if (s < 5) chk("R6", "romsel_n early", romsel_n_o, !(rd && eprom));
            else       chk("R7", "romsel_n late", romsel_n_o, a[13]);
        end
        chk("R8", "oe_n", oe_n_o, !(rd && dram && s >= 5));
        chk("R9", "dir", dir_o, wr);
        chk("R5", "refresh", refresh_o, ref_c);
    endtask

    task automatic run_cycle(input int kind, input logic [20:0] a, input logic b);
        @(negedge clk);
        chk_idle("R11");
        addr_i = a; boot_i = b; we_i = (kind == 1);
        if (kind == 2) refresh_i = 1'b1; else start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; refresh_i = 1'b0;
        for (int s = 0; s < 16; s++) begin
            if (s > 0) @(negedge clk);
            chk_slot(kind, a, b, s);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R11");          // reset state
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R11");

        // R10: all reset source combinations
        for (int k = 0; k < 4; k++) begin
            sys_reset_i = k[0]; soft_reset_i = k[1];
            #1;
            chk("R10", "mrst_n", mrst_n_o, !(k[0] || k[1]));
        end
        sys_reset_i = 1'b0; soft_reset_i = 1'b0;

        // Sweep: boot x kind x address
        for (int b = 0; b < 2; b++)
            for (int kind = 0; kind < 3; kind++)
                for (int i = 0; i < 12; i++)
                    run_cycle(kind, ADDRS[i], b[0]);

        // R11: simultaneous requests, refresh wins
        @(negedge clk);
        addr_i = 21'h000100; boot_i = 1'b1; we_i = 1'b1;
        start_i = 1'b1; refresh_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; refresh_i = 1'b0;
        chk("R11", "priority refresh", refresh_o, 1'b1);
        chk("R11", "priority dir", dir_o, 1'b0);
        for (int s = 1; s < 16; s++) begin
            @(negedge clk);
            chk_slot(2, 21'h000100, 1'b1, s);
        end

        // R11: request during a DRAM read cycle is ignored
        @(negedge clk);
        addr_i = 21'h000100; boot_i = 1'b1; we_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 0; s < 16; s++) begin
            if (s > 0) @(negedge clk);
            if (s == 3) begin
                start_i = 1'b1; we_i = 1'b1; addr_i = 21'h002000;
            end
            chk_slot(0, 21'h000100, 1'b1, s);
        end
        @(negedge clk);
        chk_idle("R11");
        start_i = 1'b0;
        @(negedge clk);
        chk_idle("R11");

        report();
    end
endmodule